// File: doc/BRIEF.md
# Debug Halt Arbitration Controller

This block decides when a processor core must stop and enter the debug halted state, and records the cause. Four halt sources compete: a fault-on-fault condition, a hardware breakpoint trigger, a decoded halt instruction, and an external breakpoint pin. The fault-on-fault and halt-instruction sources act at once. The hardware breakpoint and the pin first set a pending flag, and the core acts on that flag only at its once-per-instruction sample strobe. When several sources are due in the same cycle, only the highest-priority one is recorded.

After reset is released, the block holds off reset exception processing for a fixed number of cycles. A breakpoint pin asserted early in that interval parks the core in a reset-time halt. Only in that halt may the emulation-mode bit be written. A later GO command either skips reset exception processing, when the program counter was written while halted, or lets it run.

The controller is a five-state machine:
- `ST_RST_WAIT`: counting after reset.
- `ST_RST_EXC`: one-cycle permission to begin reset exception processing.
- `ST_RUN`: normal execution.
- `ST_HALT`: halted.
- `ST_RESUME`: one-cycle restart.

Its transitions are:
- RST_WAIT→HALT: pin asserted inside the window.
- RST_WAIT→RST_EXC: wait elapsed.
- RST_EXC→RUN: always.
- RUN→HALT: any source is due.
- HALT→RESUME: GO command.
- RESUME→RST_EXC: reset-time halt with no program-counter write.
- RESUME→RUN: otherwise.

Top module: `dbg_halt_arbiter`

## Requirements
- R1: `halt_src_o` is one-hot while halted: fault-on-fault 4'b1000, hardware breakpoint 4'b0100, halt instruction 4'b0010, breakpoint pin 4'b0001. It is 4'b0000 when not halted. When several sources are due in one cycle, only the highest-priority one is recorded, in the order fault-on-fault, hardware breakpoint, halt instruction, pin.
- R2: In RUN, `fof_i` halts the core at the next clock edge without waiting for `insn_sample_i`.
- R3: In RUN, `hwbrk_i` and `ext_brk_i` set pending flags. A pending flag halts the core only at an edge where `insn_sample_i` is high. Pending flags are not collected outside RUN, and they are cleared when the halted state is entered.
- R4: A halt instruction (`halt_insn_i`) halts the core at the next edge when `user_mode_i` is 0, or when `user_halt_en_i` is 1. In user mode without the enable, `priv_viol_o` is high in that same cycle and the core does not halt.
- R5: When no breakpoint pin is taken after reset release, `rst_exc_start_o` is high for exactly one cycle, after the 16th rising edge that follows release. The core then runs.
- R6: A pin assertion seen at any of the first 8 edges after reset release halts the core with `halt_src_o`=4'b0001. A pin assertion at the 9th through 16th edges is ignored.
- R7: `emu_mode_o` takes `emu_val_i` on an edge with `emu_wr_i` high only during a reset-time halt. Writes at any other time leave it unchanged. It is 0 after reset.
- R8: A GO command from a reset-time halt produces a resume cycle in which `rst_exc_bypass_o` equals `pc_written_i` as sampled with GO. When the bypass is 0, `rst_exc_start_o` pulses in the cycle after the resume.
- R9: While `stopped_i` is high in RUN, a pin assertion halts the core at the next edge without a sample strobe. On the following GO, `resume_next_o` is high together with `resume_req_o`.
- R10: While halted, `halt_req_o`=1 and `pst_o`=4'hF. `halt_src_o` holds the recorded source even when new sources appear, and it clears at GO. When not halted, `pst_o`=4'h0.
- R11: `resume_req_o` is high for exactly the one cycle after the edge that accepts `go_cmd_i` in the halted state. `rst_exc_bypass_o` is 0 for a GO from a run-time halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fof_i | input | 1 | Fault-on-fault condition |
| hwbrk_i | input | 1 | Hardware breakpoint trigger |
| halt_insn_i | input | 1 | Halt instruction decoded this cycle |
| user_mode_i | input | 1 | Core is in user mode |
| user_halt_en_i | input | 1 | Allows the halt instruction in user mode |
| ext_brk_i | input | 1 | External breakpoint pin |
| insn_sample_i | input | 1 | Per-instruction halt sample strobe |
| stopped_i | input | 1 | Core is in stopped mode |
| go_cmd_i | input | 1 | Debug GO command |
| pc_written_i | input | 1 | Program counter was written while halted |
| emu_wr_i | input | 1 | Write strobe for the emulation-mode bit |
| emu_val_i | input | 1 | Value for the emulation-mode bit |
| halt_req_o | output | 1 | Core must be halted |
| resume_req_o | output | 1 | Restart pulse |
| resume_next_o | output | 1 | Restart continues after the stop instruction |
| priv_viol_o | output | 1 | Privilege violation request |
| rst_exc_start_o | output | 1 | Begin reset exception processing |
| rst_exc_bypass_o | output | 1 | Skip reset exception processing on restart |
| pst_o | output | 4 | Processor status code |
| halt_src_o | output | 4 | Halt-source field for the status register |
| emu_mode_o | output | 1 | Emulation-mode bit |

## Verification
The bench builds the block with its default parameters: a 16-cycle reset wait and an 8-cycle breakpoint window. It therefore probes the exact boundary edges (the 8th versus the 9th edge for the pin, the 15th versus the 16th for the start pulse) at the values the core expects. These short windows also let every scenario restart from reset cheaply. Each halt path, each priority tie and both GO outcomes can then be reached from a clean state.

// File: rtl/dha_pkg.sv
package dha_pkg;
    typedef enum logic [2:0] {
        ST_RST_WAIT = 3'd0,
        ST_RST_EXC  = 3'd1,
        ST_RUN      = 3'd2,
        ST_HALT     = 3'd3,
        ST_RESUME   = 3'd4
    } dha_state_e;

    localparam int unsigned SRC_W = 4;
    localparam int unsigned PST_W = 4;

    // index of each source inside the due/grant vectors
    localparam int unsigned IDX_FOF   = 3;
    localparam int unsigned IDX_HWBP  = 2;
    localparam int unsigned IDX_HINSN = 1;
    localparam int unsigned IDX_PIN   = 0;

    localparam logic [SRC_W-1:0] SRC_NONE  = 4'b0000;
    localparam logic [SRC_W-1:0] SRC_PIN   = 4'b0001;

    localparam logic [PST_W-1:0] PST_ACTIVE = 4'h0;
    localparam logic [PST_W-1:0] PST_HALTED = 4'hF;
endpackage

// File: rtl/dha_rst_window.sv
module dha_rst_window #(
    parameter int unsigned WAIT_CYC = 16,
    parameter int unsigned WIN_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic in_win_o,
    output logic done_o
);
    localparam int unsigned CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign in_win_o = en_i && (cnt_q < CW'(WIN_CYC));
    assign done_o   = en_i && (cnt_q == CW'(WAIT_CYC - 1));
endmodule

// File: rtl/dha_pend.sv
module dha_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic collect_i,
    input  logic clear_i,
    input  logic hw_req_i,
    input  logic pin_req_i,
    output logic hw_pend_o,
    output logic pin_pend_o
);
    logic hw_q;
    logic pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_q  <= 1'b0;
            pin_q <= 1'b0;
        end else if (clear_i) begin
            hw_q  <= 1'b0;
            pin_q <= 1'b0;
        end else if (collect_i) begin
            hw_q  <= hw_q  | hw_req_i;
            pin_q <= pin_q | pin_req_i;
        end
    end

    // a request arriving in the sample cycle itself is taken at that sample
    assign hw_pend_o  = hw_q  | (collect_i & hw_req_i);
    assign pin_pend_o = pin_q | (collect_i & pin_req_i);
endmodule

// File: rtl/dha_src_arb.sv
module dha_src_arb #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] due_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    // highest index wins
    generate
        for (genvar i = 0; i < N; i++) begin : g_prio
            if (i == N - 1) begin : g_top
                assign grant_o[i] = due_i[i];
            end else begin : g_low
                assign grant_o[i] = due_i[i] & ~(|due_i[N-1:i+1]);
            end
        end
    endgenerate

    assign any_o = |due_i;
endmodule

// File: rtl/dbg_halt_arbiter.sv
module dbg_halt_arbiter #(
    parameter int unsigned RST_WAIT_CYC = 16,
    parameter int unsigned BRK_WIN_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fof_i,
    input  logic       hwbrk_i,
    input  logic       halt_insn_i,
    input  logic       user_mode_i,
    input  logic       user_halt_en_i,
    input  logic       ext_brk_i,
    input  logic       insn_sample_i,
    input  logic       stopped_i,
    input  logic       go_cmd_i,
    input  logic       pc_written_i,
    input  logic       emu_wr_i,
    input  logic       emu_val_i,
    output logic       halt_req_o,
    output logic       resume_req_o,
    output logic       resume_next_o,
    output logic       priv_viol_o,
    output logic       rst_exc_start_o,
    output logic       rst_exc_bypass_o,
    output logic [3:0] pst_o,
    output logic [3:0] halt_src_o,
    output logic       emu_mode_o
);
    import dha_pkg::*;

    dha_state_e       state_q, state_d;
    logic [SRC_W-1:0] src_q;
    logic             from_rst_q;
    logic             from_stop_q;
    logic             bypass_q;
    logic             emu_q;

    logic             in_win, wait_done;
    logic             run, enter_halt;
    logic             hw_pend, pin_pend;
    logic             insn_ok;
    logic [SRC_W-1:0] due, grant;
    logic             any_due;

    assign run        = (state_q == ST_RUN);
    assign enter_halt = (state_d == ST_HALT) && (state_q != ST_HALT);
    assign insn_ok    = halt_insn_i && (!user_mode_i || user_halt_en_i);

    dha_rst_window #(
        .WAIT_CYC (RST_WAIT_CYC),
        .WIN_CYC  (BRK_WIN_CYC)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (state_q == ST_RST_WAIT),
        .in_win_o (in_win),
        .done_o   (wait_done)
    );

    dha_pend u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .collect_i  (run),
        .clear_i    (enter_halt),
        .hw_req_i   (hwbrk_i),
        .pin_req_i  (ext_brk_i),
        .hw_pend_o  (hw_pend),
        .pin_pend_o (pin_pend)
    );

    always_comb begin
        due            = '0;
        due[IDX_FOF]   = run & fof_i;
        due[IDX_HWBP]  = run & insn_sample_i & hw_pend;
        due[IDX_HINSN] = run & insn_ok;
        due[IDX_PIN]   = run & (insn_sample_i | stopped_i) & pin_pend;
    end

    dha_src_arb #(.N(SRC_W)) u_arb (
        .due_i   (due),
        .grant_o (grant),
        .any_o   (any_due)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_WAIT: begin
                if (in_win && ext_brk_i) state_d = ST_HALT;
                else if (wait_done)      state_d = ST_RST_EXC;
            end
            ST_RST_EXC: state_d = ST_RUN;
            ST_RUN: begin
                if (any_due) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (go_cmd_i) state_d = ST_RESUME;
            end
            ST_RESUME: begin
                if (from_rst_q && !bypass_q) state_d = ST_RST_EXC;
                else                         state_d = ST_RUN;
            end
            default: state_d = ST_RST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST_WAIT;
        else        state_q <= state_d;
    end

    // halt context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q       <= SRC_NONE;
            from_rst_q  <= 1'b0;
            from_stop_q <= 1'b0;
            bypass_q    <= 1'b0;
        end else begin
            if (state_q == ST_RST_WAIT && state_d == ST_HALT) begin
                src_q       <= SRC_PIN;
                from_rst_q  <= 1'b1;
                from_stop_q <= 1'b0;
            end else if (run && any_due) begin
                src_q       <= grant;
                from_rst_q  <= 1'b0;
                from_stop_q <= stopped_i;
            end else if (state_q == ST_HALT && go_cmd_i) begin
                src_q    <= SRC_NONE;
                bypass_q <= from_rst_q && pc_written_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          emu_q <= 1'b0;
        else if (state_q == ST_HALT && from_rst_q && emu_wr_i) emu_q <= emu_val_i;
    end

    // outputs
    always_comb begin
        halt_req_o       = 1'b0;
        resume_req_o     = 1'b0;
        resume_next_o    = 1'b0;
        priv_viol_o      = 1'b0;
        rst_exc_start_o  = 1'b0;
        rst_exc_bypass_o = 1'b0;
        pst_o            = PST_ACTIVE;
        unique case (state_q)
            ST_RST_WAIT: ;
            ST_RST_EXC:  rst_exc_start_o = 1'b1;
            ST_RUN:      priv_viol_o = halt_insn_i && user_mode_i && !user_halt_en_i;
            ST_HALT: begin
                halt_req_o = 1'b1;
                pst_o      = PST_HALTED;
            end
            ST_RESUME: begin
                resume_req_o     = 1'b1;
                resume_next_o    = from_stop_q;
                rst_exc_bypass_o = bypass_q;
            end
            default: ;
        endcase
    end

    assign halt_src_o = src_q;
    assign emu_mode_o = emu_q;
endmodule

// File: rtl/dha_checker.sv
module dha_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state_i,
    input logic       fof_i,
    input logic       halt_insn_i,
    input logic       insn_sample_i,
    input logic       stopped_i,
    input logic       go_cmd_i,
    input logic       halt_req_o,
    input logic       resume_req_o,
    input logic       priv_viol_o,
    input logic       rst_exc_bypass_o,
    input logic [3:0] pst_o,
    input logic [3:0] halt_src_o,
    input logic       emu_mode_o
);
    import dha_pkg::*;

    logic in_run;
    assign in_run = (state_i == 3'(ST_RUN));

    p_src_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_src_o));

    p_fof_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && fof_i) |=> (halt_req_o && halt_src_o == 4'b1000));

    p_pend_needs_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !fof_i && !halt_insn_i && !insn_sample_i && !stopped_i) |=> !halt_req_o);

    p_priv_no_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_viol_o && !fof_i && !insn_sample_i && !stopped_i) |=> !halt_req_o);

    p_emu_only_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(emu_mode_o) |-> $past(halt_req_o));

    p_bypass_with_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_exc_bypass_o |-> resume_req_o);

    p_src_only_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_src_o != 4'b0000) |-> (halt_req_o && pst_o == 4'hF));

    p_resume_after_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req_o |-> ($past(go_cmd_i) && $past(halt_req_o)));
endmodule

bind dbg_halt_arbiter dha_checker u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .state_i          (state_q),
    .fof_i            (fof_i),
    .halt_insn_i      (halt_insn_i),
    .insn_sample_i    (insn_sample_i),
    .stopped_i        (stopped_i),
    .go_cmd_i         (go_cmd_i),
    .halt_req_o       (halt_req_o),
    .resume_req_o     (resume_req_o),
    .priv_viol_o      (priv_viol_o),
    .rst_exc_bypass_o (rst_exc_bypass_o),
    .pst_o            (pst_o),
    .halt_src_o       (halt_src_o),
    .emu_mode_o       (emu_mode_o)
);

// File: tb/sim_dbg_halt_arbiter.sv
`timescale 1ns/1ps
module sim_dbg_halt_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fof_i = 0, hwbrk_i = 0, halt_insn_i = 0, user_mode_i = 0;
    logic       user_halt_en_i = 0, ext_brk_i = 0, insn_sample_i = 0, stopped_i = 0;
    logic       go_cmd_i = 0, pc_written_i = 0, emu_wr_i = 0, emu_val_i = 0;
    logic       halt_req_o, resume_req_o, resume_next_o, priv_viol_o;
    logic       rst_exc_start_o, rst_exc_bypass_o, emu_mode_o;
    logic [3:0] pst_o, halt_src_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbg_halt_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .fof_i(fof_i), .hwbrk_i(hwbrk_i),
        .halt_insn_i(halt_insn_i), .user_mode_i(user_mode_i),
        .user_halt_en_i(user_halt_en_i), .ext_brk_i(ext_brk_i),
        .insn_sample_i(insn_sample_i), .stopped_i(stopped_i),
        .go_cmd_i(go_cmd_i), .pc_written_i(pc_written_i),
        .emu_wr_i(emu_wr_i), .emu_val_i(emu_val_i),
        .halt_req_o(halt_req_o), .resume_req_o(resume_req_o),
        .resume_next_o(resume_next_o), .priv_viol_o(priv_viol_o),
        .rst_exc_start_o(rst_exc_start_o), .rst_exc_bypass_o(rst_exc_bypass_o),
        .pst_o(pst_o), .halt_src_o(halt_src_o), .emu_mode_o(emu_mode_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_inputs();
        fof_i = 0; hwbrk_i = 0; halt_insn_i = 0; user_mode_i = 0;
        user_halt_en_i = 0; ext_brk_i = 0; insn_sample_i = 0; stopped_i = 0;
        go_cmd_i = 0; pc_written_i = 0; emu_wr_i = 0; emu_val_i = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        tick(2);
        rst_n = 1;
    endtask

    task automatic reset_to_run();
        do_reset();
        tick(17);
    endtask

    task automatic go(input logic pcw);
        go_cmd_i = 1; pc_written_i = pcw;
        tick();
        go_cmd_i = 0; pc_written_i = 0;
    endtask

    // R10: reset state
    task automatic t_reset_state();
        clear_inputs();
        rst_n = 0;
        tick(2);
        chk("R10 halt_req in reset", halt_req_o, 0);
        chk("R1 src in reset", halt_src_o, 0);
        chk("R10 pst in reset", pst_o, 4'h0);
        chk("R7 emu in reset", emu_mode_o, 0);
        rst_n = 1;
    endtask

    // R5: start pulse after the 16th edge
    task automatic t_reset_wait();
        do_reset();
        tick(15);
        chk("R5 no start at edge 15", rst_exc_start_o, 0);
        tick();
        chk("R5 start at edge 16", rst_exc_start_o, 1);
        tick();
        chk("R5 start is one cycle", rst_exc_start_o, 0);
        chk("R5 running after start", halt_req_o, 0);
    endtask

    // R6, R7, R8: pin at 8th edge, emu write, GO with pc
    task automatic t_window_halt_pc();
        do_reset();
        tick(7);
        ext_brk_i = 1;
        tick();
        ext_brk_i = 0;
        chk("R6 halted by pin at edge 8", halt_req_o, 1);
        chk("R6 src pin", halt_src_o, 4'b0001);
        chk("R10 pst halted", pst_o, 4'hF);
        emu_wr_i = 1; emu_val_i = 1;
        tick();
        emu_wr_i = 0; emu_val_i = 0;
        chk("R7 emu written in reset halt", emu_mode_o, 1);
        go(1);
        chk("R11 resume after GO", resume_req_o, 1);
        chk("R8 bypass with pc written", rst_exc_bypass_o, 1);
        chk("R10 src cleared at GO", halt_src_o, 0);
        tick();
        chk("R11 resume one cycle", resume_req_o, 0);
        chk("R8 no start when bypassed", rst_exc_start_o, 0);
    endtask

    // R8: GO without pc write
    task automatic t_window_halt_nopc();
        do_reset();
        ext_brk_i = 1;
        tick();
        ext_brk_i = 0;
        chk("R6 halted by pin at edge 1", halt_req_o, 1);
        tick(3);
        go(0);
        chk("R8 resume without bypass", resume_req_o, 1);
        chk("R8 bypass low", rst_exc_bypass_o, 0);
        tick();
        chk("R8 start after resume", rst_exc_start_o, 1);
        tick();
        chk("R8 running", rst_exc_start_o | halt_req_o, 0);
    endtask

    // R6, R3: pin at 9th edge ignored and not kept pending
    task automatic t_window_late();
        do_reset();
        tick(8);
        ext_brk_i = 1;
        tick();
        ext_brk_i = 0;
        chk("R6 pin at edge 9 ignored", halt_req_o, 0);
        tick(6);
        chk("R6 still waiting", rst_exc_start_o, 0);
        tick();
        chk("R5 start despite late pin", rst_exc_start_o, 1);
        tick();
        insn_sample_i = 1;
        tick();
        insn_sample_i = 0;
        chk("R3 nothing pending from wait", halt_req_o, 0);
    endtask

    // R3: hardware breakpoint waits for sample
    task automatic t_hw_pending();
        reset_to_run();
        hwbrk_i = 1;
        tick();
        hwbrk_i = 0;
        chk("R3 hw pending no halt", halt_req_o, 0);
        tick(2);
        chk("R3 hw still pending", halt_req_o, 0);
        insn_sample_i = 1;
        tick();
        insn_sample_i = 0;
        chk("R3 hw halt at sample", halt_req_o, 1);
        chk("R1 src hw", halt_src_o, 4'b0100);
        emu_wr_i = 1; emu_val_i = 1;
        tick();
        emu_wr_i = 0; emu_val_i = 0;
        chk("R7 emu write ignored in run halt", emu_mode_o, 0);
        go(1);
        chk("R11 bypass low from run halt", rst_exc_bypass_o, 0);
        chk("R9 no resume_next", resume_next_o, 0);
        tick();
    endtask

    // R2, R3, R10: fof immediate, clears pending, src held
    task automatic t_fof();
        reset_to_run();
        hwbrk_i = 1;
        tick();
        hwbrk_i = 0;
        fof_i = 1;
        tick();
        fof_i = 0;
        chk("R2 fof halts without sample", halt_req_o, 1);
        chk("R1 src fof", halt_src_o, 4'b1000);
        ext_brk_i = 1; halt_insn_i = 1;
        tick();
        ext_brk_i = 0; halt_insn_i = 0;
        chk("R10 src held while halted", halt_src_o, 4'b1000);
        go(0);
        tick();
        insn_sample_i = 1;
        tick();
        insn_sample_i = 0;
        chk("R3 pending cleared at halt entry", halt_req_o, 0);
    endtask

    // R4: halt instruction modes
    task automatic t_halt_insn();
        reset_to_run();
        halt_insn_i = 1; user_mode_i = 1;
        #0.5;
        chk("R4 priv violation in user mode", priv_viol_o, 1);
        tick();
        halt_insn_i = 0; user_mode_i = 0;
        chk("R4 no halt on violation", halt_req_o, 0);
        halt_insn_i = 1; user_mode_i = 1; user_halt_en_i = 1;
        #0.5;
        chk("R4 no violation when enabled", priv_viol_o, 0);
        tick();
        clear_inputs();
        chk("R4 user halt enabled", halt_src_o, 4'b0010);
        go(0);
        tick();
        halt_insn_i = 1;
        tick();
        halt_insn_i = 0;
        chk("R4 supervisor halt", halt_src_o, 4'b0010);
        go(0);
        tick();
    endtask

    // R1: simultaneous sources
    task automatic t_priority();
        reset_to_run();
        hwbrk_i = 1; ext_brk_i = 1;
        tick();
        hwbrk_i = 0; ext_brk_i = 0;
        halt_insn_i = 1; insn_sample_i = 1;
        tick();
        halt_insn_i = 0; insn_sample_i = 0;
        chk("R1 hw beats insn and pin", halt_src_o, 4'b0100);
        go(0);
        tick();
        ext_brk_i = 1; halt_insn_i = 1; insn_sample_i = 1;
        tick();
        clear_inputs();
        chk("R1 insn beats pin", halt_src_o, 4'b0010);
        go(0);
        tick();
        fof_i = 1; hwbrk_i = 1; ext_brk_i = 1; halt_insn_i = 1; insn_sample_i = 1;
        tick();
        clear_inputs();
        chk("R1 fof beats all", halt_src_o, 4'b1000);
        go(0);
        tick();
    endtask

    // R9: pin while stopped
    task automatic t_stopped();
        reset_to_run();
        stopped_i = 1; ext_brk_i = 1;
        tick();
        ext_brk_i = 0;
        chk("R9 halt from stop", halt_req_o, 1);
        chk("R9 src pin", halt_src_o, 4'b0001);
        stopped_i = 0;
        go(0);
        chk("R9 resume_next", resume_next_o, 1);
        tick();
        chk("R9 running again", halt_req_o, 0);
    endtask

    initial begin
        t_reset_state();
        t_reset_wait();
        t_window_halt_pc();
        t_window_halt_nopc();
        t_window_late();
        t_hw_pending();
        t_fof();
        t_halt_insn();
        t_priority();
        t_stopped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule